// File: doc/BRIEF.md
# Secondary Interrupt Status Word with Write-One-to-Clear

This block holds the second interrupt status word of a network controller. Four event sources are caught in sticky bits: transmit early, receive early, transmit deferred and pause frame received. Software clears a caught event by writing a 1 to its bit position. Three of the four sources are qualified by an enable. The transmit-early and receive-early events each have their own enable. The pause event is accepted only while the pause function is on.

The word has two other parts. One bit is a live summary of a 7-bit transceiver interrupt vector. A 3-bit field mirrors the bus error type, but only while the fatal bus error flag is high. The block drives a single interrupt line from the sticky bits and the transceiver summary. Software reads the word directly on `status_q` and writes through a one-cycle write strobe with a 32-bit data word.

Top module: `irq_stat2`

## Requirements
- R1: After reset, every sticky bit (31, 30, 28, 26) reads 0.
- R2: Bit 31 becomes 1 on the clock edge after a cycle with `tx_early_evt` and `tx_early_en` both high. An event with the enable low leaves it unchanged.
- R3: Bit 30 becomes 1 on the clock edge after a cycle with `rx_early_evt` and `rx_early_en` both high. An event with the enable low leaves it unchanged.
- R4: Bit 28 becomes 1 on the clock edge after a cycle with `tx_defer_evt` high.
- R5: Bit 26 becomes 1 on the clock edge after a cycle with `pause_rx_evt` and `pause_en` both high. A pause event while `pause_en` is low leaves it unchanged.
- R6: A write (`wr_en` high) with a 1 in a sticky bit position clears that bit on the next edge. A 0 in that position leaves the bit unchanged.
- R7: When a set event and a write-1 clear hit the same sticky bit in the same cycle, the bit reads 1 afterwards.
- R8: Bit 29 always equals the OR of `xcvr_irq_vec[6:0]`, in the same cycle and without latching.
- R9: Bits 25:23 equal `bus_err_code` while `fatal_bus_err` is high and read 000 otherwise. The codes are 000 parity error, 001 master abort and 010 target abort; 011 and 1xx are reserved.
- R10: `irq` equals the OR of bits 31, 30, 29, 28 and 26. The error-type field never raises `irq`.
- R11: Bit 27 and bits 22:0 always read 0. Writes to bits 29, 27, 25:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_early_evt | input | 1 | Transmit packet moved into transmit FIFO (one-cycle pulse) |
| tx_early_en | input | 1 | Enable for transmit-early capture |
| rx_early_evt | input | 1 | First receive descriptor filled (one-cycle pulse) |
| rx_early_en | input | 1 | Enable for receive-early capture |
| tx_defer_evt | input | 1 | Transmit deferred event (one-cycle pulse) |
| pause_rx_evt | input | 1 | Pause frame received (one-cycle pulse) |
| pause_en | input | 1 | Pause function enabled |
| xcvr_irq_vec | input | 7 | Transceiver interrupt sources |
| fatal_bus_err | input | 1 | Fatal bus error flag |
| bus_err_code | input | 3 | Bus error type code |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; a 1 clears the matching sticky bit |
| status_q | output | 32 | Status word read value |
| irq | output | 1 | Combined interrupt request |

## Verification
A sticky bit that holds the wrong value is visible on `status_q` and on `irq` one edge after the event or write that should have changed it. The bench therefore samples every step just after that edge. A broken set-over-clear priority shows up only in the cycle where both hit the same bit, so that collision is driven on purpose. Faults in the live parts (the transceiver summary and the gated error field) appear in the same cycle as the input change, with no edge needed.

// File: rtl/irq_stat2_pkg.sv
package irq_stat2_pkg;
  localparam int WORD_W  = 32;
  localparam int XV_W    = 7;
  localparam int ERR_W   = 3;
  localparam int N_LAT   = 4;

  // bit positions software decodes
  localparam int POS_TXE = 31;
  localparam int POS_RXE = 30;
  localparam int POS_XV  = 29;
  localparam int POS_DEF = 28;
  localparam int POS_PAU = 26;
  localparam int ERR_LSB = 23;
  localparam int ERR_MSB = ERR_LSB + ERR_W - 1;

  // sticky slot i sits at LAT_POS[i]
  localparam int LAT_POS [N_LAT] = '{POS_TXE, POS_RXE, POS_DEF, POS_PAU};

  typedef enum logic [ERR_W-1:0] {
    BERR_PARITY = 3'b000,
    BERR_MABORT = 3'b001,
    BERR_TABORT = 3'b010
  } berr_e;

  // error-type view: visible only while the fatal flag is up
  function automatic logic [ERR_W-1:0] err_view(input logic fatal,
                                                 input logic [ERR_W-1:0] code);
    return fatal ? code : '0;
  endfunction

  // interrupt summary from sticky slots and transceiver vector
  function automatic logic irq_sum(input logic [N_LAT-1:0] lat,
                                   input logic [XV_W-1:0] xv);
    return (|lat) | (|xv);
  endfunction
endpackage

// File: rtl/irq_stat2_cell.sv
module irq_stat2_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over a write-one clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/irq_stat2_pack.sv
module irq_stat2_pack
  import irq_stat2_pkg::*;
#(
  parameter int XW = XV_W,
  parameter int EW = ERR_W
) (
  input  logic [N_LAT-1:0]  lat_i,
  input  logic [XW-1:0]     xv_i,
  input  logic              fatal_i,
  input  logic [EW-1:0]     code_i,
  output logic [WORD_W-1:0] word_o,
  output logic              irq_o
);
  always_comb begin
    word_o = '0;
    for (int i = 0; i < N_LAT; i++) word_o[LAT_POS[i]] = lat_i[i];
    word_o[POS_XV] = |xv_i;
    word_o[ERR_LSB +: EW] = err_view(fatal_i, code_i);
  end

  assign irq_o = irq_sum(lat_i, xv_i);
endmodule

// File: rtl/irq_stat2.sv
module irq_stat2
  import irq_stat2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_early_evt,
  input  logic              tx_early_en,
  input  logic              rx_early_evt,
  input  logic              rx_early_en,
  input  logic              tx_defer_evt,
  input  logic              pause_rx_evt,
  input  logic              pause_en,
  input  logic [XV_W-1:0]   xcvr_irq_vec,
  input  logic              fatal_bus_err,
  input  logic [ERR_W-1:0]  bus_err_code,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] status_q,
  output logic              irq
);
  // qualified set events, slot order follows LAT_POS
  logic [N_LAT-1:0] set_v;
  logic [N_LAT-1:0] clr_v;
  logic [N_LAT-1:0] lat_v;

  assign set_v[0] = tx_early_evt & tx_early_en;
  assign set_v[1] = rx_early_evt & rx_early_en;
  assign set_v[2] = tx_defer_evt;
  assign set_v[3] = pause_rx_evt & pause_en;

  for (genvar g = 0; g < N_LAT; g++) begin : g_lat
    assign clr_v[g] = wr_en & wr_data[LAT_POS[g]];
    irq_stat2_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (lat_v[g])
    );
  end

  irq_stat2_pack #(.XW(XV_W), .EW(ERR_W)) u_pack (
    .lat_i   (lat_v),
    .xv_i    (xcvr_irq_vec),
    .fatal_i (fatal_bus_err),
    .code_i  (bus_err_code),
    .word_o  (status_q),
    .irq_o   (irq)
  );

  p_txe_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_early_en && !status_q[POS_TXE]) |=> !status_q[POS_TXE]);
  p_rxe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_early_en && !status_q[POS_RXE]) |=> !status_q[POS_RXE]);
  p_def_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_defer_evt |=> status_q[POS_DEF]);
  p_pau_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_en && !status_q[POS_PAU]) |=> !status_q[POS_PAU]);
  p_xcvr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[POS_XV] == (xcvr_irq_vec != '0));
  p_err_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fatal_bus_err |-> (status_q[ERR_MSB:ERR_LSB] == '0));
  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status_q[POS_TXE] | status_q[POS_RXE] | status_q[POS_XV]
            | status_q[POS_DEF] | status_q[POS_PAU]));
  p_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[27] == 1'b0) && (status_q[ERR_LSB-1:0] == '0));
endmodule

// File: tb/sim_irq_stat2.sv
module sim_irq_stat2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_early_evt = 0, tx_early_en = 0, rx_early_evt = 0, rx_early_en = 0;
  logic        tx_defer_evt = 0, pause_rx_evt = 0, pause_en = 0;
  logic [6:0]  xcvr_irq_vec = '0;
  logic        fatal_bus_err = 0;
  logic [2:0]  bus_err_code = '0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] status_q;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  irq_stat2 u0 (.*);

  typedef struct packed {
    logic        txe, txen, rxe, rxen, df, pz, pzen;
    logic [6:0]  vec;
    logic        fatal;
    logic [2:0]  code;
    logic        wr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        eirq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1,0,0,0,0,0,0, 7'h00, 0,3'd0, 0,32'h0,        32'h0000_0000, 0, 4'd2},  // R2 gated
    '{1,1,0,0,0,0,0, 7'h00, 0,3'd0, 0,32'h0,        32'h8000_0000, 1, 4'd2},  // R2 set
    '{0,0,1,0,0,0,0, 7'h00, 0,3'd0, 0,32'h0,        32'h8000_0000, 1, 4'd3},  // R3 gated
    '{0,0,1,1,0,0,0, 7'h00, 0,3'd0, 0,32'h0,        32'hC000_0000, 1, 4'd3},  // R3 set
    '{0,0,0,0,0,0,0, 7'h00, 0,3'd0, 1,32'h8000_0000,32'h4000_0000, 1, 4'd6},  // R6 clear
    '{0,0,0,0,0,0,0, 7'h00, 0,3'd0, 1,32'h0,        32'h4000_0000, 1, 4'd6},  // R6 zero write
    '{0,0,0,0,1,0,0, 7'h00, 0,3'd0, 0,32'h0,        32'h5000_0000, 1, 4'd4},  // R4
    '{0,0,0,0,0,1,0, 7'h00, 0,3'd0, 0,32'h0,        32'h5000_0000, 1, 4'd5},  // R5 gated
    '{0,0,0,0,0,1,1, 7'h00, 0,3'd0, 0,32'h0,        32'h5400_0000, 1, 4'd5},  // R5 set
    '{0,0,0,0,0,0,0, 7'h00, 0,3'd0, 1,32'hFFFF_FFFF,32'h0000_0000, 0, 4'd11}, // R11 / R6
    '{0,0,0,0,0,0,0, 7'h40, 0,3'd0, 0,32'h0,        32'h2000_0000, 1, 4'd8},  // R8
    '{0,0,0,0,0,0,0, 7'h00, 1,3'd2, 0,32'h0,        32'h0100_0000, 0, 4'd10}, // R10 / R9 target abort
    '{0,0,0,0,0,0,0, 7'h00, 0,3'd2, 0,32'h0,        32'h0000_0000, 0, 4'd9},  // R9 hidden
    '{0,0,0,0,0,0,0, 7'h00, 1,3'd1, 0,32'h0,        32'h0080_0000, 0, 4'd9},  // R9 master abort
    '{0,0,0,0,0,0,0, 7'h00, 1,3'd0, 0,32'h0,        32'h0000_0000, 0, 4'd9},  // R9 parity
    '{0,0,0,0,1,0,0, 7'h00, 0,3'd0, 1,32'h1000_0000,32'h1000_0000, 1, 4'd7},  // R7 set wins
    '{0,0,0,0,0,0,0, 7'h00, 0,3'd0, 1,32'h1000_0000,32'h0000_0000, 0, 4'd6}   // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    tx_early_evt = 0; tx_early_en = 0; rx_early_evt = 0; rx_early_en = 0;
    tx_defer_evt = 0; pause_rx_evt = 0; pause_en = 0; xcvr_irq_vec = '0;
    fatal_bus_err = 0; bus_err_code = '0; wr_en = 0; wr_data = '0;
  endtask

  // drive at negedge, sample 1 ns after the following posedge
  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #0.1;
    chk("R1 reset word", status_q, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tx_early_evt = TBL[i].txe; tx_early_en = TBL[i].txen;
      rx_early_evt = TBL[i].rxe; rx_early_en = TBL[i].rxen;
      tx_defer_evt = TBL[i].df;  pause_rx_evt = TBL[i].pz; pause_en = TBL[i].pzen;
      xcvr_irq_vec = TBL[i].vec; fatal_bus_err = TBL[i].fatal; bus_err_code = TBL[i].code;
      wr_en = TBL[i].wr; wr_data = TBL[i].wd;
      step();
      chk($sformatf("R%0d vec%0d word", TBL[i].req, i), status_q, TBL[i].exp);
      chk($sformatf("R10 vec%0d irq", i), {31'b0, irq}, {31'b0, TBL[i].eirq});
    end

    // R11: writes to reserved / read-only positions do not appear
    @(negedge clk); idle(); wr_en = 1; wr_data = 32'h2BFF_FFFF;
    step();
    chk("R11 ignored write", status_q, 32'h0);

    // R8: live, follows the vector without a clock edge
    @(negedge clk); idle(); xcvr_irq_vec = 7'h01;
    #0.5;
    chk("R8 same cycle", status_q, 32'h2000_0000);
    xcvr_irq_vec = 7'h00;
    #0.5;
    chk("R8 drops", status_q, 32'h0);

    // R7: all four collide with clears
    @(negedge clk); idle();
    tx_early_evt = 1; tx_early_en = 1; rx_early_evt = 1; rx_early_en = 1;
    tx_defer_evt = 1; pause_rx_evt = 1; pause_en = 1;
    wr_en = 1; wr_data = 32'hFFFF_FFFF;
    step();
    chk("R7 all set wins", status_q, 32'hD400_0000);

    // R1: reset clears sticky bits
    @(negedge clk); idle(); rst_n = 0;
    #1;
    chk("R1 async reset", status_q, 32'h0);
    @(negedge clk); rst_n = 1;
    step();
    chk("R1 stays clear", status_q, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule